// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block produces the address sequence for a synchronous burst memory. An external address is captured whenever either of two address-strobe inputs is high at a rising clock edge. From that start point the block walks through a group of four beats, changing only the two least significant address bits and only on edges where the advance input is high. The upper address bits stay as loaded for the whole group.

A mode input selects the order of the low bits. In linear order they count up from the start offset and wrap modulo four. In interleaved order they are the start offset XOR the beat number. A burst-active flag is high from the load until the fourth beat has been passed. Because a load may be issued on every cycle, a controller that never advances gets one fresh random address per clock at no throughput cost.

All outputs are registered, so every input change shows on the outputs one clock edge after it is sampled.

Top module: `bag_burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `addr_out` = 0 and `burst_active` = 0, and the beat number returns to zero.
- R2: When `strobe_cpu` or `strobe_ctl` is high at an edge, `addr_out` equals the sampled `ext_addr` after that edge, the beat number restarts at zero and `burst_active` goes to 1.
- R3: When both strobes are high in the same cycle, the processor-side strobe `strobe_cpu` is granted, exactly one load takes place, and `advance` is ignored in that cycle (the beat number after the edge is zero).
- R4: With no strobe and `advance` low, `addr_out` and `burst_active` keep their values; `order_xor` is sampled only on edges where a load or an advance happens, so changing it during a hold has no effect.
- R5: With `order_xor` = 0 (linear), after an advance the low two bits of `addr_out` equal (start offset + beat number) modulo 4, where the beat number is incremented by one per advance.
- R6: With `order_xor` = 1 (interleaved), after an advance the low two bits of `addr_out` equal start offset XOR beat number.
- R7: Address bits above bit 1 change only on a load; advances never alter them, including when the beat number wraps.
- R8: An advance taken while the beat number is 3 (fourth beat issued) clears `burst_active`; further advances keep wrapping within the same four-beat group with `burst_active` staying 0.
- R9: Loads on consecutive cycles each take effect, so every cycle can present a new external address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External start address |
| strobe_cpu | input | 1 | Processor-side address strobe, higher priority |
| strobe_ctl | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step to the next beat |
| order_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current full address |
| burst_active | output | 1 | High while beats of the group remain |

## Verification
The assertions assume that all inputs are settled and free of unknowns at each rising edge and that reset is held for at least one edge before the first real command, since the load and hold properties compare against values sampled one cycle earlier. The bench drives every input on the falling edge from a single driver task and keeps `order_xor` constant inside each checked burst, except in the deliberate hold test, so the linear and interleaved expectations each refer to one order. A reference model in the bench computes each expected address from the start offset and a beat count, never from the design's state.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } load_src_e;

  // Low-bit position for a beat: linear add or XOR with the start offset.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input burst_order_e ord);
    if (ord == ORD_XOR) return start ^ beat;
    else                return start + beat;
  endfunction

endpackage

// File: rtl/bag_strobe_arb.sv
module bag_strobe_arb
  import bag_pkg::*;
(
  input  logic      strobe_cpu,
  input  logic      strobe_ctl,
  input  logic      advance,
  output logic      load,
  output logic      step,
  output load_src_e src
);

  always_comb begin
    if (strobe_cpu)      src = SRC_CPU;
    else if (strobe_ctl) src = SRC_CTL;
    else                 src = SRC_NONE;
  end

  assign load = (src != SRC_NONE);
  // A load always wins over an advance in the same cycle.
  assign step = advance && !load;

endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [BEAT_W-1:0] cnt_nxt,
  output logic              active_q
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  logic active_nxt;

  always_comb begin
    cnt_nxt    = cnt_q;
    active_nxt = active_q;
    if (load) begin
      cnt_nxt    = '0;
      active_nxt = 1'b1;
    end else if (step) begin
      cnt_nxt = cnt_q + 1'b1;
      if (cnt_q == LAST_BEAT) active_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      active_q <= active_nxt;
    end
  end

  // R8
  last_beat_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt_q == LAST_BEAT) |=> (!active_q && cnt_q == '0));

endmodule

// File: rtl/bag_addr_seq.sv
module bag_addr_seq
  import bag_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ext_addr,
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] cnt_nxt,
  output logic [ADDR_W-1:0] addr_q
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_nxt;
  logic [BEAT_W-1:0] low_nxt;

  assign base_nxt = load ? ext_addr : base_q;

  generate
    if (BEAT_W == 2) begin : g_two_bit
      assign low_nxt = beat_offset(base_nxt[1:0], cnt_nxt, order);
    end else begin : g_wide
      assign low_nxt = (order == ORD_XOR) ? (base_nxt[BEAT_W-1:0] ^ cnt_nxt)
                                          : (base_nxt[BEAT_W-1:0] + cnt_nxt);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else begin
      base_q <= base_nxt;
      if (load || step) addr_q <= {base_nxt[ADDR_W-1:BEAT_W], low_nxt};
    end
  end

  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(addr_q));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (addr_q[ADDR_W-1:BEAT_W] == $past(addr_q[ADDR_W-1:BEAT_W])));

  localparam int UNUSED_HI = HI_W;

endmodule

// File: rtl/bag_burst_addr_gen.sv
module bag_burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              order_xor,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);

  logic              load;
  logic              step;
  load_src_e         src;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_nxt;
  burst_order_e      order;

  assign order = order_xor ? ORD_XOR : ORD_LINEAR;

  bag_strobe_arb u_arb (
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .load       (load),
    .step       (step),
    .src        (src)
  );

  bag_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .active_q (burst_active)
  );

  bag_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .ext_addr (ext_addr),
    .order    (order),
    .cnt_nxt  (cnt_nxt),
    .addr_q   (addr_out)
  );

  // R2
  load_takes_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_cpu || strobe_ctl) |=> (addr_out == $past(ext_addr) && burst_active && cnt_q == '0));

  // R3
  both_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_cpu && strobe_ctl) |-> (src == SRC_CPU && !step));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && !burst_active && cnt_q == '0));

endmodule

// File: tb/test_bag_burst_addr_gen.sv
`timescale 1ns/1ps
module test_bag_burst_addr_gen;

  localparam int AW = 19;

  typedef struct {
    logic [AW-1:0] addr;
    logic          act;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_cpu = 1'b0;
  logic          strobe_ctl = 1'b0;
  logic          advance = 1'b0;
  logic          order_xor = 1'b0;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  // model state
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_act = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #2.5 clk = ~clk;

  bag_burst_addr_gen i_bag_burst_addr_gen (
    .clk, .rst, .ext_addr, .strobe_cpu, .strobe_ctl,
    .advance, .order_xor, .addr_out, .burst_active
  );

  function automatic logic [AW-1:0] calc(logic [AW-1:0] b, logic [1:0] c, logic x);
    logic [1:0] lo;
    lo = x ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[AW-1:2], lo};
  endfunction

  task automatic drive(input logic r, input logic cpu, input logic ctl,
                       input logic adv, input logic x, input logic [AW-1:0] a,
                       input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; strobe_cpu = cpu; strobe_ctl = ctl; advance = adv;
    order_xor = x; ext_addr = a;
    if (r) begin
      m_base = '0; m_cnt = '0; m_act = 1'b0; m_addr = '0;
    end else if (cpu || ctl) begin
      m_base = a; m_cnt = '0; m_act = 1'b1; m_addr = calc(m_base, m_cnt, x);
    end else if (adv) begin
      if (m_cnt == 2'd3) m_act = 1'b0;
      m_cnt = m_cnt + 2'd1;
      m_addr = calc(m_base, m_cnt, x);
    end
    e.addr = m_addr; e.act = m_act; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one cycle after each driven item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (addr_out !== e.addr || burst_active !== e.act) begin
          errors++;
          $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                   e.tag, addr_out, burst_active, e.addr, e.act);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset
    drive(1, 0, 0, 0, 0, 19'h0, "R1");
    drive(1, 1, 0, 1, 1, 19'h7FFFF, "R1");
    // R2 load via processor strobe, linear, start offset 2
    drive(0, 1, 0, 0, 0, 19'h12346, "R2");
    // R5 linear steps: 3,0,1
    drive(0, 0, 0, 1, 0, 19'h0, "R5");
    drive(0, 0, 0, 1, 0, 19'h0, "R5");
    drive(0, 0, 0, 1, 0, 19'h0, "R5");
    // R4 hold with mode toggled and address changing
    drive(0, 0, 0, 0, 1, 19'h55555, "R4");
    drive(0, 0, 0, 0, 0, 19'h2AAAA, "R4");
    // R8 advance past fourth beat clears active, then wraps
    drive(0, 0, 0, 1, 0, 19'h0, "R8");
    drive(0, 0, 0, 1, 0, 19'h0, "R8");
    drive(0, 0, 0, 1, 0, 19'h0, "R8");
    // R2 load via controller strobe, interleaved, start offset 1
    drive(0, 0, 1, 0, 1, 19'h0ABC1, "R2");
    // R6 interleaved: 0,3,2
    drive(0, 0, 0, 1, 1, 19'h0, "R6");
    drive(0, 0, 0, 1, 1, 19'h0, "R6");
    drive(0, 0, 0, 1, 1, 19'h0, "R6");
    drive(0, 0, 0, 1, 1, 19'h0, "R8");
    // R7 upper bits fixed across wrap from top of range
    drive(0, 1, 0, 0, 0, 19'h7FFFF, "R7");
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 1, 0, 19'h0, "R7");
    // R3 both strobes with advance: single load, advance ignored
    drive(0, 0, 0, 1, 0, 19'h0, "R3");
    drive(0, 1, 1, 1, 1, 19'h31F02, "R3");
    drive(0, 0, 0, 1, 1, 19'h0, "R3");
    // R9 back-to-back loads, alternating strobes
    for (int i = 0; i < 6; i++)
      drive(0, i[0], !i[0], 1, i[1], 19'h10000 + 19'(i * 37), "R9");
    drive(0, 0, 0, 0, 0, 19'h0, "R4");
    // R1 reset mid-burst
    drive(1, 0, 0, 1, 0, 19'h0, "R1");
    drive(0, 0, 0, 0, 0, 19'h0, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule